// File: doc/BRIEF.md
# Periodic Down-Counter Interrupt Timer

This block is a 32-bit down-counter that raises a level interrupt when its count reaches a programmed compare value. Software controls it through a small word-addressed register port with five registers: control, status, load, compare and a read-only live count. The counter does not decrement on every clock. It steps on enable pulses. A 2-bit source select picks one of three tick inputs, or none. A 12-bit divider then passes one step for every (divider + 1) selected ticks.

Two behaviours apply when the count reaches zero. In reload mode the counter restarts from the load register. In free-running mode it wraps to all ones. An enable-mode bit chooses what happens when the timer is switched on: the counter either starts again or keeps its frozen value. A software reset clears most of the state and keeps a few control bits. An immediate-overwrite option makes a load-register write also set the counter at once. The low-power and debug control bits are stored and read back, and have no other effect.

Top module: `pdt_timer`

## Requirements
- R1: After hard reset, control, status and compare read 0, load reads 0xFFFFFFFF, count reads 0xFFFFFFFF, and `irq` is low.
- R2: Register offsets are: 0 control, 1 status, 2 load, 3 compare and 4 count. Offsets 5 to 7 read as 0, and writes to them change no register. Count is read-only. Load and compare read back the value written.
- R3: Control register fields:
  - bit 0 enable
  - bit 1 enable-mode
  - bit 2 compare-interrupt enable
  - bit 3 reload mode
  - bits 15:4 divider
  - bit 16 software reset
  - bit 17 immediate overwrite
  - bits 21:18 stored only
  - bits 25:24 tick source

  Bits 31:26, 23:22 and 16 always read 0. A write of 0xFFFEFFFF reads back as 0x033EFFFF.
- R4: A count step needs enable set and a nonzero source. Source 01 selects `tick_in[0]`, 10 selects `tick_in[1]` and 11 selects `tick_in[2]`; source 00 gives no steps. One step occurs for every (divider + 1) pulses of the selected input. Pulses on the other inputs have no effect.
- R5: A control write that takes enable from 0 to 1 with enable-mode set loads the counter, which reads back on the next cycle. The value loaded is the load register in reload mode, and 0xFFFFFFFF otherwise.
- R6: While enable is clear the count holds its value. A 0-to-1 enable with enable-mode clear resumes counting from that held value.
- R7: Each step decrements the count by one. A step at count 0 loads the load register in reload mode, or 0xFFFFFFFF in free-running mode.
- R8: The compare flag (status bit 0) is set by a step whose new count equals the compare register. The flag stays set until it is cleared.
- R9: Writing status with bit 0 = 1 clears the flag, and writing bit 0 = 0 leaves it unchanged. A flag-set step in the same cycle as a clearing write leaves the flag set.
- R10: `irq` is high exactly when the flag, the compare-interrupt enable and the enable bit are all set.
- R11: With immediate overwrite set, a load-register write also loads the counter. Without it, the counter is unchanged until its next reload.
- R12: A control write with bit 16 set keeps the written bits 0, 1 and 21:18, and clears every other control bit. In the same write it clears status and compare, sets load to 0xFFFFFFFF and sets the counter to 0xFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_in | input | 3 | Tick pulses for sources 01, 10 and 11 (one clock wide, synchronous) |
| reg_wr | input | 1 | Register write strobe, one write per cycle |
| reg_addr | input | 3 | Word offset for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational from current state |
| irq | output | 1 | Level interrupt |

## Verification
The checker module watches the per-cycle properties of the counter and flag on every cycle. These are:
- a step decrements the count;
- a free-running wrap lands on all ones;
- a disabled counter holds still;
- steps occur only when enabled and with a source selected;
- the flag is sticky, and a step that matches the compare value wins over a clear in the same cycle;
- `irq` never rises without its three conditions.

Other behaviour is shown only by the bench's scenarios:
- the exact values loaded when enable rises;
- the divider ratio and the choice of source;
- the field masking and the bits retained by software reset;
- the register side effects of immediate overwrite.

// File: rtl/pdt_pkg.sv
package pdt_pkg;
  localparam int unsigned DATA_W = 32;

  // word offsets
  localparam int unsigned OFF_CTRL = 0;
  localparam int unsigned OFF_STAT = 1;
  localparam int unsigned OFF_LOAD = 2;
  localparam int unsigned OFF_CMP  = 3;
  localparam int unsigned OFF_CNT  = 4;

  // control bit positions
  localparam int unsigned B_EN     = 0;
  localparam int unsigned B_ENMODE = 1;
  localparam int unsigned B_CIE    = 2;
  localparam int unsigned B_RELOAD = 3;
  localparam int unsigned B_DIV_LO = 4;
  localparam int unsigned B_SWRST  = 16;
  localparam int unsigned B_OVWR   = 17;
  localparam int unsigned B_SRC_LO = 24;

  localparam logic [DATA_W-1:0] CTRL_WMASK = 32'h033E_FFFF;
  localparam logic [DATA_W-1:0] CTRL_KEEP  = 32'h003C_0003;
  localparam logic [DATA_W-1:0] ALL_ONES   = '1;
endpackage

// File: rtl/pdt_prescale.sv
module pdt_prescale #(
  parameter int unsigned DIV_W = 12,
  parameter int unsigned SRC_W = 2,
  localparam int unsigned N_SRC = (1 << SRC_W) - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [SRC_W-1:0] src_sel,
  input  logic [N_SRC-1:0] tick_in,
  input  logic [DIV_W-1:0] div,
  output logic             step
);
  logic [N_SRC:0]   src_vec;
  logic             tick;
  logic [DIV_W-1:0] pcnt;

  assign src_vec = {tick_in, 1'b0};  // source 0 selects a constant zero
  assign tick    = src_vec[src_sel];
  assign step    = run && tick && (pcnt >= div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pcnt <= '0;
    else if (!run)    pcnt <= '0;
    else if (step)    pcnt <= '0;
    else if (tick)    pcnt <= pcnt + 1'b1;
  end
endmodule

// File: rtl/pdt_counter.sv
module pdt_counter #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic         reload_mode,
  input  logic [W-1:0] load_val,
  input  logic [W-1:0] cmp_val,
  input  logic         force_en,
  input  logic [W-1:0] force_val,
  output logic [W-1:0] cnt,
  output logic         hit
);
  logic [W-1:0] nxt;

  always_comb begin
    if (cnt == '0) nxt = reload_mode ? load_val : '1;
    else           nxt = cnt - 1'b1;
  end

  assign hit = step && !force_en && (nxt == cmp_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '1;
    else if (force_en) cnt <= force_val;
    else if (step)     cnt <= nxt;
  end
endmodule

// File: rtl/pdt_regs.sv
module pdt_regs
  import pdt_pkg::*;
#(
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              hit,
  input  logic [DATA_W-1:0] cnt_val,
  output logic [DATA_W-1:0] ctrl_q,
  output logic [DATA_W-1:0] load_q,
  output logic [DATA_W-1:0] cmp_q,
  output logic              flag_q,
  output logic              irq,
  output logic              cnt_force,
  output logic [DATA_W-1:0] cnt_fval,
  output logic [DATA_W-1:0] reg_rdata
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STAT);
  localparam logic [ADDR_W-1:0] A_LOAD = ADDR_W'(OFF_LOAD);
  localparam logic [ADDR_W-1:0] A_CMP  = ADDR_W'(OFF_CMP);
  localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(OFF_CNT);

  logic              wr_ctrl, wr_stat, wr_load, wr_cmp, swr, en_rise;
  logic [DATA_W-1:0] ctrl_new;

  assign wr_ctrl = reg_wr && (reg_addr == A_CTRL);
  assign wr_stat = reg_wr && (reg_addr == A_STAT);
  assign wr_load = reg_wr && (reg_addr == A_LOAD);
  assign wr_cmp  = reg_wr && (reg_addr == A_CMP);
  assign swr     = wr_ctrl && reg_wdata[B_SWRST];

  assign ctrl_new = swr ? (reg_wdata & CTRL_KEEP) : (reg_wdata & CTRL_WMASK);
  assign en_rise  = wr_ctrl && ctrl_new[B_EN] && !ctrl_q[B_EN];

  // counter overrides, most specific first
  always_comb begin
    cnt_force = 1'b0;
    cnt_fval  = ALL_ONES;
    if (swr) begin
      cnt_force = 1'b1;
    end else if (en_rise && ctrl_new[B_ENMODE]) begin
      cnt_force = 1'b1;
      cnt_fval  = ctrl_new[B_RELOAD] ? load_q : ALL_ONES;
    end else if (wr_load && ctrl_q[B_OVWR]) begin
      cnt_force = 1'b1;
      cnt_fval  = reg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      load_q <= ALL_ONES;
      cmp_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_new;
      if (swr) begin
        load_q <= ALL_ONES;
        cmp_q  <= '0;
        flag_q <= 1'b0;
      end else begin
        if (wr_load) load_q <= reg_wdata;
        if (wr_cmp)  cmp_q  <= reg_wdata;
        if (hit)                          flag_q <= 1'b1;
        else if (wr_stat && reg_wdata[0]) flag_q <= 1'b0;
      end
    end
  end

  assign irq = flag_q && ctrl_q[B_CIE] && ctrl_q[B_EN];

  always_comb begin
    unique case (reg_addr)
      A_CTRL:  reg_rdata = ctrl_q;
      A_STAT:  reg_rdata = {{(DATA_W-1){1'b0}}, flag_q};
      A_LOAD:  reg_rdata = load_q;
      A_CMP:   reg_rdata = cmp_q;
      A_CNT:   reg_rdata = cnt_val;
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/pdt_timer.sv
module pdt_timer
  import pdt_pkg::*;
#(
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned DIV_W  = 12,
  parameter int unsigned SRC_W  = 2,
  localparam int unsigned N_SRC = (1 << SRC_W) - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  tick_in,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  logic [DATA_W-1:0] ctrl_q, load_q, cmp_q, cnt_q, cnt_fval;
  logic              flag_q, cnt_force, step, hit, run;

  pdt_regs #(.ADDR_W(ADDR_W)) i_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .hit(hit), .cnt_val(cnt_q), .ctrl_q(ctrl_q),
    .load_q(load_q), .cmp_q(cmp_q), .flag_q(flag_q), .irq(irq),
    .cnt_force(cnt_force), .cnt_fval(cnt_fval), .reg_rdata(reg_rdata)
  );

  assign run = ctrl_q[B_EN] && (ctrl_q[B_SRC_LO +: SRC_W] != '0);

  pdt_prescale #(.DIV_W(DIV_W), .SRC_W(SRC_W)) i_pre (
    .clk(clk), .rst_n(rst_n), .run(run),
    .src_sel(ctrl_q[B_SRC_LO +: SRC_W]), .tick_in(tick_in),
    .div(ctrl_q[B_DIV_LO +: DIV_W]), .step(step)
  );

  pdt_counter #(.W(DATA_W)) i_cnt (
    .clk(clk), .rst_n(rst_n), .step(step), .reload_mode(ctrl_q[B_RELOAD]),
    .load_val(load_q), .cmp_val(cmp_q), .force_en(cnt_force),
    .force_val(cnt_fval), .cnt(cnt_q), .hit(hit)
  );
endmodule

// File: rtl/pdt_timer_chk.sv
module pdt_timer_chk
  import pdt_pkg::*;
#(
  parameter int unsigned ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              irq,
  input logic [DATA_W-1:0] ctrl_q,
  input logic              flag_q,
  input logic [DATA_W-1:0] cnt_q,
  input logic              step,
  input logic              hit,
  input logic              cnt_force
);
  logic clr_wr, swr_wr;
  assign clr_wr = reg_wr && (reg_addr == ADDR_W'(OFF_STAT)) && reg_wdata[0];
  assign swr_wr = reg_wr && (reg_addr == ADDR_W'(OFF_CTRL)) && reg_wdata[B_SWRST];

  AST_CTRL_ZERO_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_W'(OFF_CTRL)) |-> (reg_rdata[31:26] == '0 && !reg_rdata[B_SWRST])); // R3
  AST_STEP_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (ctrl_q[B_EN] && ctrl_q[B_SRC_LO +: 2] != 2'b00)); // R4
  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q[B_EN] && !cnt_force) |=> $stable(cnt_q)); // R6
  AST_STEP_DECREMENTS: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !cnt_force && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 32'd1)); // R7
  AST_FREE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !cnt_force && cnt_q == '0 && !ctrl_q[B_RELOAD]) |=> (cnt_q == ALL_ONES)); // R7
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr_wr && !swr_wr) |=> flag_q); // R8
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !swr_wr) |=> flag_q); // R9
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flag_q && ctrl_q[B_CIE] && ctrl_q[B_EN])); // R10
endmodule

bind pdt_timer pdt_timer_chk #(.ADDR_W(ADDR_W)) i_chk (.*);

// File: tb/test_pdt_timer.sv
module test_pdt_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  tick_in = '0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  pdt_timer i_pdt_timer (
    .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  typedef struct packed {
    logic        wr;
    logic [2:0]  addr;
    logic [31:0] data;
    logic [2:0]  tick;
    logic        chk;
    logic [31:0] exp;
    logic        irq_exp;
    logic [7:0]  rq;
  } vec_t;

  localparam vec_t VEC [0:30] = '{
    '{1'b0,3'd0,32'h0,3'b000,1'b1,32'h0,1'b0,8'd1},          // R1 ctrl
    '{1'b0,3'd2,32'h0,3'b000,1'b1,32'hFFFFFFFF,1'b0,8'd1},   // R1 load
    '{1'b0,3'd4,32'h0,3'b000,1'b1,32'hFFFFFFFF,1'b0,8'd1},   // R1 count
    '{1'b0,3'd1,32'h0,3'b000,1'b1,32'h0,1'b0,8'd1},          // R1 status
    '{1'b1,3'd2,32'h5,3'b000,1'b0,32'h0,1'b0,8'd2},          // R2 load=5
    '{1'b1,3'd3,32'h3,3'b000,1'b0,32'h0,1'b0,8'd2},          // R2 cmp=3
    '{1'b0,3'd2,32'h0,3'b000,1'b1,32'h5,1'b0,8'd2},
    '{1'b0,3'd3,32'h0,3'b000,1'b1,32'h3,1'b0,8'd2},
    '{1'b1,3'd0,32'h0100000F,3'b000,1'b0,32'h0,1'b0,8'd5},   // R5 start, reload
    '{1'b0,3'd4,32'h0,3'b000,1'b1,32'h5,1'b0,8'd5},
    '{1'b0,3'd0,32'h0,3'b000,1'b1,32'h0100000F,1'b0,8'd3},   // R3 readback
    '{1'b0,3'd4,32'h0,3'b001,1'b1,32'h5,1'b0,8'd7},          // R7 5->4
    '{1'b0,3'd4,32'h0,3'b001,1'b1,32'h4,1'b0,8'd7},          // 4->3 hit
    '{1'b0,3'd1,32'h0,3'b000,1'b1,32'h1,1'b1,8'd8},          // R8 flag
    '{1'b0,3'd4,32'h0,3'b001,1'b1,32'h3,1'b1,8'd7},
    '{1'b0,3'd4,32'h0,3'b001,1'b1,32'h2,1'b1,8'd7},
    '{1'b0,3'd4,32'h0,3'b001,1'b1,32'h1,1'b1,8'd7},
    '{1'b0,3'd4,32'h0,3'b001,1'b1,32'h0,1'b1,8'd7},          // 0 -> reload 5
    '{1'b0,3'd4,32'h0,3'b000,1'b1,32'h5,1'b1,8'd7},
    '{1'b1,3'd1,32'h0,3'b000,1'b0,32'h0,1'b1,8'd9},          // R9 write 0
    '{1'b0,3'd1,32'h0,3'b000,1'b1,32'h1,1'b1,8'd9},
    '{1'b1,3'd1,32'h1,3'b000,1'b0,32'h0,1'b1,8'd9},          // R9 clear
    '{1'b0,3'd1,32'h0,3'b000,1'b1,32'h0,1'b0,8'd9},
    '{1'b1,3'd0,32'h0000000F,3'b000,1'b0,32'h0,1'b0,8'd4},   // R4 source 00
    '{1'b0,3'd4,32'h0,3'b111,1'b1,32'h5,1'b0,8'd4},
    '{1'b0,3'd4,32'h0,3'b000,1'b1,32'h5,1'b0,8'd4},
    '{1'b1,3'd0,32'h0300001F,3'b000,1'b0,32'h0,1'b0,8'd4},   // R4 src 11, div 1
    '{1'b0,3'd4,32'h0,3'b100,1'b1,32'h5,1'b0,8'd4},
    '{1'b0,3'd4,32'h0,3'b100,1'b1,32'h5,1'b0,8'd4},
    '{1'b0,3'd4,32'h0,3'b011,1'b1,32'h4,1'b0,8'd4},          // other sources
    '{1'b0,3'd4,32'h0,3'b000,1'b1,32'h4,1'b0,8'd4}
  };

  task automatic cmp(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic cyc(input logic wr, input logic [2:0] a, input logic [31:0] d,
                     input logic [2:0] t);
    @(negedge clk);
    reg_wr = wr; reg_addr = a; reg_wdata = d; tick_in = t;
    @(posedge clk);
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string what);
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = a; tick_in = '0;
    #1 cmp(what, reg_rdata, exp);
    @(posedge clk);
  endtask

  task automatic irq_chk(input logic exp, input string what);
    @(negedge clk);
    reg_wr = 1'b0; tick_in = '0;
    #1 cmp(what, {31'b0, irq}, {31'b0, exp});
    @(posedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < 5000; i++) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // table walk
    for (int i = 0; i <= 30; i++) begin
      @(negedge clk);
      reg_wr = VEC[i].wr; reg_addr = VEC[i].addr;
      reg_wdata = VEC[i].data; tick_in = VEC[i].tick;
      #1;
      if (VEC[i].chk) cmp($sformatf("R%0d vec %0d data", VEC[i].rq, i), reg_rdata, VEC[i].exp);
      cmp($sformatf("R%0d vec %0d irq", VEC[i].rq, i), {31'b0, irq}, {31'b0, VEC[i].irq_exp});
      @(posedge clk);
    end
    // R2 unmapped offsets
    rd(3'd5, 32'h0, "R2 offset 5");
    cyc(1'b1, 3'd6, 32'hDEAD_BEEF, 3'b000);
    rd(3'd2, 32'h5, "R2 load after offset-6 write");
    rd(3'd7, 32'h0, "R2 offset 7");
    cyc(1'b1, 3'd4, 32'h1234, 3'b000);
    rd(3'd4, 32'h4, "R2 count read-only");
    // R6 freeze while disabled
    cyc(1'b1, 3'd0, 32'h0100_0000, 3'b000);
    cyc(1'b0, 3'd0, 32'h0, 3'b001);
    rd(3'd4, 32'h4, "R6 frozen");
    // R5 free-running start, R11 overwrite, R7 wrap
    cyc(1'b1, 3'd0, 32'h0102_0003, 3'b000);
    rd(3'd4, 32'hFFFF_FFFF, "R5 start all ones");
    cyc(1'b0, 3'd0, 32'h0, 3'b001);
    rd(3'd4, 32'hFFFF_FFFE, "R7 decrement");
    cyc(1'b1, 3'd2, 32'h2, 3'b000);
    rd(3'd4, 32'h2, "R11 immediate overwrite");
    for (int k = 0; k < 3; k++) cyc(1'b0, 3'd0, 32'h0, 3'b001);
    rd(3'd4, 32'hFFFF_FFFF, "R7 free wrap");
    // R6 resume without enable-mode
    cyc(1'b1, 3'd0, 32'h0100_0000, 3'b000);
    cyc(1'b0, 3'd0, 32'h0, 3'b001);
    cyc(1'b1, 3'd0, 32'h0100_0001, 3'b000);
    rd(3'd4, 32'hFFFF_FFFF, "R6 resume value");
    cyc(1'b0, 3'd0, 32'h0, 3'b001);
    rd(3'd4, 32'hFFFF_FFFE, "R6 resumed count");
    // R11 no overwrite in reload mode
    cyc(1'b1, 3'd0, 32'h0100_0009, 3'b000);
    cyc(1'b1, 3'd2, 32'h1, 3'b000);
    rd(3'd4, 32'hFFFF_FFFE, "R11 count kept");
    // R9 set beats clear in same cycle
    cyc(1'b1, 3'd3, 32'hFFFF_FFFD, 3'b000);
    cyc(1'b1, 3'd0, 32'h0100_000D, 3'b000);
    cyc(1'b1, 3'd1, 32'h1, 3'b001);
    rd(3'd1, 32'h1, "R9 set wins");
    irq_chk(1'b1, "R10 irq high");
    // R10 gate off by compare-interrupt enable
    cyc(1'b1, 3'd0, 32'h0100_0009, 3'b000);
    irq_chk(1'b0, "R10 irq masked");
    rd(3'd1, 32'h1, "R10 flag kept");
    // R12 software reset
    cyc(1'b1, 3'd0, 32'hFFFF_FFFF, 3'b000);
    rd(3'd0, 32'h003C_0003, "R12 ctrl kept bits");
    rd(3'd1, 32'h0, "R12 status");
    rd(3'd2, 32'hFFFF_FFFF, "R12 load");
    rd(3'd3, 32'h0, "R12 compare");
    rd(3'd4, 32'hFFFF_FFFF, "R12 count");
    cyc(1'b0, 3'd0, 32'h0, 3'b111);
    rd(3'd4, 32'hFFFF_FFFF, "R12 source cleared");
    // R3 write mask
    cyc(1'b1, 3'd0, 32'hFFFE_FFFF, 3'b000);
    rd(3'd0, 32'h033E_FFFF, "R3 write mask");
    // R1 hard reset mid-run
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    rd(3'd0, 32'h0, "R1 ctrl after reset");
    rd(3'd4, 32'hFFFF_FFFF, "R1 count after reset");
    irq_chk(1'b0, "R1 irq after reset");
    done = 1'b1;
    summary();
  end
endmodule